// File: doc/BRIEF.md
# Request-Acknowledge Timing Monitor

This block is a synthesizable monitor that watches a one-bit request line and a one-bit acknowledge line on a shared clock and checks three timing windows. It times all three from the same rising edge of the request: how soon the acknowledge arrives, how many cycles the request stays high, and how soon the request drops once the acknowledge has been seen. Each window has a sticky error flag and a one-cycle pulse that marks the cycle in which the violation is found.

The monitor follows one handshake at a time. A `busy_o` output shows when a handshake is being timed. Rising edges of the request that arrive while `busy_o` is high are ignored. The monitor is placed beside a handshake interface, and its flags are read after traffic has run or are routed to an interrupt source. Only the synchronous reset clears the flags.

Top module: `handshake_window_monitor`

## Requirements
- R1: A check starts at a clock edge where `req` is sampled 1 and was sampled 0 at the previous edge, while the monitor is idle. `busy_o` is high in the cycle after that edge.
- R2: Number the rising-edge sample as offset 0. If `ack` is sampled 1 at no offset from 0 to 10, the acknowledge error is raised at offset 10.
- R3: An `ack` sampled high at offset 0, together with the rising request, is a valid acknowledge and raises no error.
- R4: The count of consecutive high `req` samples starting at offset 0 must lie between 5 and 7. The width error is raised when `req` is sampled low after fewer than 5 high samples, or when an 8th high sample is seen.
- R5: If `ack` is first seen at offset A, `req` must be sampled low at an offset from A to A+10. Otherwise the release error is raised at offset A+10. A `req` that is already low at offset A passes.
- R6: When the acknowledge error is raised, the release check for that handshake is dropped and never reports.
- R7: Each error output (`ack_err_o`, `width_err_o`, `rel_err_o`) stays high from its first violation until a synchronous reset.
- R8: Each pulse output is high for exactly one cycle per violation: the cycle after the deciding edge. The matching sticky output is already high in that cycle.
- R9: A rising edge of `req` while `busy_o` is high starts no new check and changes no result of the check in progress.
- R10: `busy_o` falls in the cycle after the last active check passes or fails. That edge is offset max(width end, acknowledge/release end).
- R11: With `rst` high at a clock edge, every output is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request line being watched |
| ack | input | 1 | Acknowledge line being watched |
| ack_err_o | output | 1 | Sticky: acknowledge came too late or never came |
| width_err_o | output | 1 | Sticky: request high for too few or too many cycles |
| rel_err_o | output | 1 | Sticky: request stayed high too long after the acknowledge |
| ack_pulse_o | output | 1 | One-cycle marker of an acknowledge violation |
| width_pulse_o | output | 1 | One-cycle marker of a width violation |
| rel_pulse_o | output | 1 | One-cycle marker of a release violation |
| busy_o | output | 1 | A handshake is being timed |

## Verification
The embedded properties assume that `req` and `ack` are sampled synchronously and are clean 0/1 values, with no X. They also assume reset is asserted from time zero. The stimulus changes the inputs only on the falling clock edge. Every handshake is followed by a low period long enough for the monitor to return to idle, apart from one directed case that deliberately raises the request a second time during a check. Random handshakes pick an acknowledge offset from 0 to 13 and a request width from 1 to 12, so both sides of every window boundary are reached.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
    typedef enum logic [1:0] {
        AR_IDLE     = 2'd0,
        AR_WAIT_ACK = 2'd1,
        AR_WAIT_REL = 2'd2
    } ar_state_e;
endpackage

// File: rtl/hwm_rise_detect.sv
module hwm_rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic rise_o
);
    typedef struct packed {
        logic req;
    } rd_t;

    rd_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = req_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise_o = req_i & ~st_q.req;
endmodule

// File: rtl/hwm_width_check.sv
module hwm_width_check #(
    parameter int WID_MIN = 5,
    parameter int WID_MAX = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic req_i,
    output logic busy_o,
    output logic fail_o
);
    localparam int CW = $clog2(WID_MAX + 1);
    localparam logic [CW-1:0] MIN_C = CW'(WID_MIN);
    localparam logic [CW-1:0] MAX_C = CW'(WID_MAX);

    typedef struct packed {
        logic          active;
        logic          fail;
        logic [CW-1:0] cnt;
    } wc_t;

    wc_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fail = 1'b0;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = CW'(1);
        end else if (st_q.active) begin
            if (!req_i) begin
                st_d.active = 1'b0;
                st_d.fail   = (st_q.cnt < MIN_C);
            end else if (st_q.cnt >= MAX_C) begin
                st_d.active = 1'b0;
                st_d.fail   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o = st_q.active;
    assign fail_o = st_q.fail;

    assert_width_cnt_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.active |-> (st_q.cnt >= CW'(1) && st_q.cnt <= MAX_C));

    assert_start_idle_R9: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !st_q.active);

    assert_fail_ends_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.fail |-> !st_q.active);
endmodule

// File: rtl/hwm_ack_release.sv
module hwm_ack_release
    import hwm_pkg::*;
#(
    parameter int ACK_MAX = 10,
    parameter int REL_MAX = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic req_i,
    input  logic ack_i,
    output logic busy_o,
    output logic ack_fail_o,
    output logic rel_fail_o
);
    localparam int LIM = (ACK_MAX > REL_MAX) ? ACK_MAX : REL_MAX;
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] ACK_C = CW'(ACK_MAX);
    localparam logic [CW-1:0] REL_C = CW'(REL_MAX);

    typedef struct packed {
        ar_state_e     state;
        logic [CW-1:0] cnt;
        logic          ack_fail;
        logic          rel_fail;
    } ar_t;

    ar_t st_d, st_q;
    logic [CW-1:0] nxt_cnt;

    always_comb begin
        st_d          = st_q;
        st_d.ack_fail = 1'b0;
        st_d.rel_fail = 1'b0;
        nxt_cnt       = st_q.cnt + 1'b1;
        unique case (st_q.state)
            AR_IDLE: begin
                if (start_i) begin
                    st_d.cnt   = '0;
                    st_d.state = ack_i ? AR_WAIT_REL : AR_WAIT_ACK;
                end
            end
            AR_WAIT_ACK: begin
                if (ack_i) begin
                    st_d.cnt   = '0;
                    st_d.state = req_i ? AR_WAIT_REL : AR_IDLE;
                end else if (nxt_cnt >= ACK_C) begin
                    st_d.ack_fail = 1'b1;
                    st_d.state    = AR_IDLE;
                end else begin
                    st_d.cnt = nxt_cnt;
                end
            end
            AR_WAIT_REL: begin
                if (!req_i) begin
                    st_d.state = AR_IDLE;
                end else if (nxt_cnt >= REL_C) begin
                    st_d.rel_fail = 1'b1;
                    st_d.state    = AR_IDLE;
                end else begin
                    st_d.cnt = nxt_cnt;
                end
            end
            default: st_d.state = AR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{state: AR_IDLE, cnt: '0, ack_fail: 1'b0, rel_fail: 1'b0};
        else     st_q <= st_d;
    end

    assign busy_o     = (st_q.state != AR_IDLE);
    assign ack_fail_o = st_q.ack_fail;
    assign rel_fail_o = st_q.rel_fail;

    assert_ack_fail_noack_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.ack_fail |-> !$past(ack_i));

    assert_abandon_rel_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.ack_fail |-> (st_q.state == AR_IDLE && !st_q.rel_fail));

    assert_rel_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == AR_WAIT_REL) |-> (st_q.cnt < REL_C));

    assert_ack_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == AR_WAIT_ACK) |-> (st_q.cnt < ACK_C));
endmodule

// File: rtl/handshake_window_monitor.sv
module handshake_window_monitor #(
    parameter int ACK_MAX = 10,
    parameter int WID_MIN = 5,
    parameter int WID_MAX = 7,
    parameter int REL_MAX = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ack,
    output logic ack_err_o,
    output logic width_err_o,
    output logic rel_err_o,
    output logic ack_pulse_o,
    output logic width_pulse_o,
    output logic rel_pulse_o,
    output logic busy_o
);
    typedef struct packed {
        logic ack_err;
        logic wid_err;
        logic rel_err;
    } stk_t;

    stk_t st_d, st_q;
    logic rise, start;
    logic wid_busy, ar_busy;
    logic wid_fail, ack_fail, rel_fail;

    hwm_rise_detect u_rise (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .rise_o (rise)
    );

    assign start = rise & ~busy_o;

    hwm_width_check #(.WID_MIN(WID_MIN), .WID_MAX(WID_MAX)) u_width (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .req_i   (req),
        .busy_o  (wid_busy),
        .fail_o  (wid_fail)
    );

    hwm_ack_release #(.ACK_MAX(ACK_MAX), .REL_MAX(REL_MAX)) u_ackrel (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .req_i      (req),
        .ack_i      (ack),
        .busy_o     (ar_busy),
        .ack_fail_o (ack_fail),
        .rel_fail_o (rel_fail)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ack_err = st_q.ack_err | ack_fail;
        st_d.wid_err = st_q.wid_err | wid_fail;
        st_d.rel_err = st_q.rel_err | rel_fail;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o        = wid_busy | ar_busy;
    assign ack_pulse_o   = ack_fail;
    assign width_pulse_o = wid_fail;
    assign rel_pulse_o   = rel_fail;
    assign ack_err_o     = st_q.ack_err | ack_fail;
    assign width_err_o   = st_q.wid_err | wid_fail;
    assign rel_err_o     = st_q.rel_err | rel_fail;

    assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_o);

    assert_sticky_ack_R7: assert property (@(posedge clk) disable iff (rst)
        ack_err_o |=> ack_err_o);
    assert_sticky_width_R7: assert property (@(posedge clk) disable iff (rst)
        width_err_o |=> width_err_o);
    assert_sticky_rel_R7: assert property (@(posedge clk) disable iff (rst)
        rel_err_o |=> rel_err_o);

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_pulse_o | width_pulse_o | rel_pulse_o) |=>
        !($past(ack_pulse_o) && ack_pulse_o) && !($past(width_pulse_o) && width_pulse_o)
        && !($past(rel_pulse_o) && rel_pulse_o));

    assert_no_dual_ackrel_R6: assert property (@(posedge clk) disable iff (rst)
        !(ack_pulse_o && rel_pulse_o));
endmodule

// File: tb/handshake_window_monitor_tb.sv
`timescale 1ns/1ps
module handshake_window_monitor_tb;
    localparam int ACK_MAX = 10;
    localparam int WID_MIN = 5;
    localparam int WID_MAX = 7;
    localparam int REL_MAX = 10;
    localparam int SPAN    = 26;

    logic clk = 1'b0;
    logic rst, req, ack;
    logic ack_err_o, width_err_o, rel_err_o;
    logic ack_pulse_o, width_pulse_o, rel_pulse_o, busy_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit sk_ack, sk_wid, sk_rel;

    always #2.5 clk = ~clk;

    handshake_window_monitor #(
        .ACK_MAX(ACK_MAX), .WID_MIN(WID_MIN), .WID_MAX(WID_MAX), .REL_MAX(REL_MAX)
    ) u_dut (
        .clk(clk), .rst(rst), .req(req), .ack(ack),
        .ack_err_o(ack_err_o), .width_err_o(width_err_o), .rel_err_o(rel_err_o),
        .ack_pulse_o(ack_pulse_o), .width_pulse_o(width_pulse_o),
        .rel_pulse_o(rel_pulse_o), .busy_o(busy_o)
    );

    task automatic chk(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic bit f_ack(int a);
        return a > ACK_MAX;
    endfunction

    function automatic bit f_wid(int w);
        return (w < WID_MIN) || (w > WID_MAX);
    endfunction

    function automatic bit f_rel(int a, int w);
        return !f_ack(a) && (w > a) && ((w - a) > REL_MAX);
    endfunction

    function automatic int f_end(int a, int w);
        int we, ae;
        we = (w <= WID_MAX) ? w : WID_MAX;
        if (a > ACK_MAX)  ae = ACK_MAX;
        else if (w <= a)  ae = a;
        else              ae = a + (((w - a) < REL_MAX) ? (w - a) : REL_MAX);
        return (we > ae) ? we : ae;
    endfunction

    task automatic do_reset();
        rst = 1'b1; req = 1'b0; ack = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sk_ack = 0; sk_wid = 0; sk_rel = 0;
        chk({ack_err_o, width_err_o, rel_err_o, ack_pulse_o, width_pulse_o,
             rel_pulse_o, busy_o} == 7'b0, "R11 reset outputs",
            int'({ack_err_o, width_err_o, rel_err_o, ack_pulse_o, width_pulse_o,
                  rel_pulse_o, busy_o}), 0);
    endtask

    // One handshake: ack high for one sample at offset a, req high for offsets 0..w-1,
    // plus an optional second high stretch at es..es+el-1.
    task automatic run_txn(int a, int w, int es, int el, string tag);
        int pa = 0, pw = 0, pr = 0, nb = 0;
        bit first_busy = 1'b0, e_a, e_w, e_r;
        bit sync_bad = 1'b0;
        e_a = f_ack(a); e_w = f_wid(w); e_r = f_rel(a, w);
        for (int t = 0; t < SPAN; t++) begin
            req = (t < w) || (t >= es && t < es + el);
            ack = (t == a);
            @(posedge clk);
            @(negedge clk);
            if (t == 0) first_busy = busy_o;
            pa += int'(ack_pulse_o);
            pw += int'(width_pulse_o);
            pr += int'(rel_pulse_o);
            nb += int'(busy_o);
            if ((ack_pulse_o && !ack_err_o) || (width_pulse_o && !width_err_o) ||
                (rel_pulse_o && !rel_err_o)) sync_bad = 1'b1;
        end
        req = 1'b0; ack = 1'b0;
        sk_ack |= e_a; sk_wid |= e_w; sk_rel |= e_r;
        chk(first_busy, {"R1 busy after rise ", tag}, int'(first_busy), 1);
        chk(pa == int'(e_a), {"R2 ack pulses ", tag}, pa, int'(e_a));
        chk(pw == int'(e_w), {"R4 width pulses ", tag}, pw, int'(e_w));
        chk(pr == int'(e_r), {"R5 R6 release pulses ", tag}, pr, int'(e_r));
        chk(nb == f_end(a, w), {"R10 busy cycles ", tag}, nb, f_end(a, w));
        chk(!sync_bad, {"R8 sticky with pulse ", tag}, int'(sync_bad), 0);
        chk({ack_err_o, width_err_o, rel_err_o} == {sk_ack, sk_wid, sk_rel},
            {"R7 sticky flags ", tag},
            int'({ack_err_o, width_err_o, rel_err_o}), int'({sk_ack, sk_wid, sk_rel}));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R3: ack together with the rising request, legal width
        run_txn(0, 6, 0, 0, "R3 ack at rise");
        // R2 boundary: ack at offset 10 accepted, 11 too late
        run_txn(10, 7, 0, 0, "R2 ack at 10");
        do_reset();
        run_txn(11, 6, 0, 0, "R2 ack at 11");
        do_reset();
        // R4 boundaries
        run_txn(2, 4, 0, 0, "R4 width 4");
        do_reset();
        run_txn(2, 5, 0, 0, "R4 width 5");
        run_txn(2, 8, 0, 0, "R4 width 8");
        do_reset();
        // R5 boundary: fall exactly 10 after ack passes, 11 fails
        run_txn(1, 11, 0, 0, "R5 release 10");
        do_reset();
        run_txn(0, 11, 0, 0, "R5 release 11");
        do_reset();
        // R5: req already low when ack arrives
        run_txn(8, 5, 0, 0, "R5 low at ack");
        // R6: ack fails, release would also fail but is dropped
        do_reset();
        run_txn(13, 12, 0, 0, "R6 abandon");
        // R7: flag kept through a clean handshake
        run_txn(3, 6, 0, 0, "R7 hold");
        // R9: second rise while busy is ignored
        do_reset();
        run_txn(9, 2, 4, 3, "R9 overlap");
        // random handshakes
        for (int i = 0; i < 60; i++) begin
            int a, w;
            if (($urandom % 4) == 0) do_reset();
            a = int'($urandom_range(0, 13));
            w = int'($urandom_range(1, 12));
            run_txn(a, w, 0, 0, "random");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule